// File: doc/BRIEF.md
# Load/Store Byte-Lane Alignment Unit

This unit sits between the execute stage of a 64-bit integer pipeline and a 64-bit little-endian data memory port. For every memory operation it adds a sign-extended 12-bit displacement to a base register to form the effective address. It also decides whether the access is naturally aligned. For stores, it places the low bytes of the source operand onto the matching byte lanes and raises a byte strobe for each lane that is written.

For loads, the unit records the lane offset, the access width and the extension mode when the request is issued. When the memory port returns its 64-bit word, the unit shifts the addressed bytes down to bit 0 and then applies sign or zero extension for the recorded width. Accesses that are not naturally aligned are flagged and never reach the memory port. The unit does not split them into smaller accesses.

The request side is purely combinational, so the memory request appears in the same cycle as the execute-stage request. One load may be outstanding at a time. The memory answers it with a single-cycle `mem_rvalid` pulse on a later cycle.

Top module: `lsu_align_unit`

## Requirements
- R1: `mem_addr` equals `req_base` plus the 12-bit `req_imm` sign-extended to 64 bits, with the sum taken modulo 2^64.
- R2: The access width is encoded on `req_size` as 0 for 1 byte, 1 for 2 bytes, 2 for 4 bytes and 3 for 8 bytes. When `mem_addr[2:0]` is not a multiple of the width, `req_misaligned` is high and `mem_req` is low. Otherwise, under `req_valid`, `mem_req` is high and `req_misaligned` is low.
- R3: For an issued store, `mem_we` is high and `mem_strb` has one bit set for each byte of the width. These bits are contiguous and start at bit `mem_addr[2:0]`. Strobe bit k belongs to data bits 8k+7..8k.
- R4: For an issued store, byte k of `req_wsrc` (k below the width) appears on lane `mem_addr[2:0]`+k of `mem_wdata`. All lanes outside the strobe are driven to zero.
- R5: For an issued load, `mem_we` is low and `mem_strb` marks the lanes that will be read, using the same rule as R3.
- R6: When `mem_rvalid` arrives while a load is pending, `ld_valid` is high in that same cycle. The bytes of `ld_data` are taken from lanes offset, offset+1, and so on of `mem_rdata`, where offset is the address bits 2:0 captured at issue.
- R7: A load with `req_zext` low and a width of 1, 2 or 4 bytes returns the value sign-extended from the top bit of the loaded field to 64 bits.
- R8: A load with `req_zext` high and a width of 1, 2 or 4 bytes returns the value zero-extended to 64 bits.
- R9: An 8-byte load returns all 64 bits of `mem_rdata` unchanged, whatever the value of `req_zext`.
- R10: While `rst_n` is low and in the first cycle after reset, no load is pending, and `ld_valid` stays low even if `mem_rvalid` is high.
- R11: A `mem_rvalid` that arrives with no load pending leaves `ld_valid` low. This covers a response after a store, and a response after a misaligned load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Execute stage presents a memory operation |
| req_store | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | Access width code (0:1B, 1:2B, 2:4B, 3:8B) |
| req_zext | input | 1 | Load extension mode: 1 = zero-extend, 0 = sign-extend |
| req_base | input | 64 | Base register value |
| req_imm | input | 12 | Signed displacement |
| req_wsrc | input | 64 | Store source register value |
| mem_req | output | 1 | Memory request issued |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 64 | Effective byte address |
| mem_strb | output | 8 | Byte-lane strobes |
| mem_wdata | output | 64 | Lane-steered store data |
| mem_rvalid | input | 1 | Load data returned by memory |
| mem_rdata | input | 64 | Returned 64-bit word |
| req_misaligned | output | 1 | Request not naturally aligned |
| ld_valid | output | 1 | Extracted load result valid |
| ld_data | output | 64 | Extracted and extended load result |

## Verification
The hardest case to reach is the match between the bytes and sign bit chosen on the response and the offset and width recorded one or more cycles earlier. A fault in the captured context only shows up when the returned word has different sign bits in different lanes. The bench therefore sweeps every width, offset and extension mode against two complementary read-back words. For each case it derives the effective address first and then computes the base from it, so that offsets are reached with both positive and negative displacements. It also sends responses after stores and after misaligned loads, which shows that no stale context is consumed.

// File: rtl/lsu_align_pkg.sv
package lsu_align_pkg;

  localparam int unsigned DW   = 64;
  localparam int unsigned NB   = DW / 8;
  localparam int unsigned OW   = $clog2(NB);
  localparam int unsigned IMMW = 12;

  typedef enum logic [1:0] {
    SZ_B = 2'd0,
    SZ_H = 2'd1,
    SZ_W = 2'd2,
    SZ_D = 2'd3
  } acc_size_e;

  typedef struct packed {
    logic [OW-1:0] off;
    acc_size_e     size;
    logic          zext;
  } ld_ctx_t;

  function automatic logic [DW-1:0] sext_imm(input logic [IMMW-1:0] imm);
    return {{(DW-IMMW){imm[IMMW-1]}}, imm};
  endfunction

  function automatic logic [NB-1:0] width_mask(input acc_size_e sz);
    logic [NB-1:0] m;
    m = '0;
    for (int i = 0; i < int'(NB); i++) begin
      if (i < (1 << int'(sz))) m[i] = 1'b1;
    end
    return m;
  endfunction

  function automatic logic is_misaligned(input logic [OW-1:0] off, input acc_size_e sz);
    logic [OW-1:0] lowm;
    lowm = OW'((1 << int'(sz)) - 1);
    return |(off & lowm);
  endfunction

  function automatic logic [DW-1:0] extend_field(input logic [DW-1:0] raw,
                                                 input acc_size_e sz,
                                                 input logic zext);
    logic [DW-1:0] r;
    case (sz)
      SZ_B:    r = {{(DW-8){~zext & raw[7]}}, raw[7:0]};
      SZ_H:    r = {{(DW-16){~zext & raw[15]}}, raw[15:0]};
      SZ_W:    r = {{(DW-32){~zext & raw[31]}}, raw[31:0]};
      default: r = raw;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/lsu_addr_gen.sv
module lsu_addr_gen
  import lsu_align_pkg::*;
#(
  parameter int unsigned ADDR_W = DW,
  parameter int unsigned IMM_W  = IMMW,
  parameter int unsigned OFF_W  = OW
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [IMM_W-1:0]  imm,
  input  acc_size_e         size,
  output logic [ADDR_W-1:0] ea,
  output logic [OFF_W-1:0]  off,
  output logic              misal
);
  assign ea    = base + sext_imm(imm);
  assign off   = ea[OFF_W-1:0];
  assign misal = is_misaligned(off, size);
endmodule

// File: rtl/lsu_store_steer.sv
module lsu_store_steer
  import lsu_align_pkg::*;
#(
  parameter int unsigned DATA_W = DW,
  parameter int unsigned LANES  = NB,
  parameter int unsigned OFF_W  = OW
) (
  input  logic [DATA_W-1:0] src,
  input  logic [OFF_W-1:0]  off,
  input  acc_size_e         size,
  output logic [LANES-1:0]  strb,
  output logic [DATA_W-1:0] lanes
);
  assign strb = width_mask(size) << off;

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    logic [OFF_W-1:0] rel;
    assign rel = OFF_W'(j) - off;
    assign lanes[8*j +: 8] = strb[j] ? src[8*rel +: 8] : 8'h00;
  end
endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract
  import lsu_align_pkg::*;
#(
  parameter int unsigned DATA_W = DW
) (
  input  logic [DATA_W-1:0] rdata,
  input  ld_ctx_t           ctx,
  output logic [DATA_W-1:0] data
);
  logic [DATA_W-1:0] shifted;
  assign shifted = rdata >> {ctx.off, 3'b000};
  assign data    = extend_field(shifted, ctx.size, ctx.zext);
endmodule

// File: rtl/lsu_align_unit.sv
module lsu_align_unit
  import lsu_align_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_store,
  input  logic [1:0]    req_size,
  input  logic          req_zext,
  input  logic [DW-1:0] req_base,
  input  logic [IMMW-1:0] req_imm,
  input  logic [DW-1:0] req_wsrc,
  output logic          mem_req,
  output logic          mem_we,
  output logic [DW-1:0] mem_addr,
  output logic [NB-1:0] mem_strb,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_rvalid,
  input  logic [DW-1:0] mem_rdata,
  output logic          req_misaligned,
  output logic          ld_valid,
  output logic [DW-1:0] ld_data
);
  acc_size_e     size_w;
  logic [DW-1:0] ea_w;
  logic [OW-1:0] off_w;
  logic          misal_w;
  logic          issue_load;
  logic          pending_q;
  ld_ctx_t       ctx_q;
  logic [1:0]    pend_size;
  logic          pend_zext;

  assign size_w = acc_size_e'(req_size);

  lsu_addr_gen u_addr (
    .base  (req_base),
    .imm   (req_imm),
    .size  (size_w),
    .ea    (ea_w),
    .off   (off_w),
    .misal (misal_w)
  );

  lsu_store_steer u_steer (
    .src   (req_wsrc),
    .off   (off_w),
    .size  (size_w),
    .strb  (mem_strb),
    .lanes (mem_wdata)
  );

  assign mem_addr       = ea_w;
  assign mem_req        = req_valid & ~misal_w;
  assign mem_we         = mem_req & req_store;
  assign req_misaligned = req_valid & misal_w;
  assign issue_load     = mem_req & ~req_store;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending_q <= 1'b0;
      ctx_q     <= '0;
    end else if (issue_load) begin
      pending_q <= 1'b1;
      ctx_q     <= '{off: off_w, size: size_w, zext: req_zext};
    end else if (mem_rvalid) begin
      pending_q <= 1'b0;
    end
  end

  assign pend_size = ctx_q.size;
  assign pend_zext = ctx_q.zext;

  lsu_load_extract u_extract (
    .rdata (mem_rdata),
    .ctx   (ctx_q),
    .data  (ld_data)
  );

  assign ld_valid = mem_rvalid & pending_q;
endmodule

// File: rtl/lsu_align_checker.sv
module lsu_align_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        req_store,
  input logic [1:0]  req_size,
  input logic        mem_req,
  input logic        mem_we,
  input logic [7:0]  mem_strb,
  input logic        mem_rvalid,
  input logic        req_misaligned,
  input logic        ld_valid,
  input logic [63:0] ld_data,
  input logic        pending_q,
  input logic [1:0]  pend_size,
  input logic        pend_zext
);
  p_misaligned_blocks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_misaligned |-> !mem_req);

  p_strobe_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> ($countones(mem_strb) == (1 << req_size)));

  p_store_writes_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && req_store) |-> mem_we);

  p_load_pending_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we) |=> pending_q);

  p_orphan_response_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rvalid && !pending_q) |-> !ld_valid);

  p_zext_byte_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && pend_zext && pend_size == 2'd0) |-> (ld_data[63:8] == '0));

  p_sext_word_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && !pend_zext && pend_size == 2'd2) |->
      (ld_data[63:31] == '0 || ld_data[63:31] == '1));

  p_reset_idle_r10: assert property (@(posedge clk)
    !rst_n |=> !pending_q);
endmodule

bind lsu_align_unit lsu_align_checker u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .req_store      (req_store),
  .req_size       (req_size),
  .mem_req        (mem_req),
  .mem_we         (mem_we),
  .mem_strb       (mem_strb),
  .mem_rvalid     (mem_rvalid),
  .req_misaligned (req_misaligned),
  .ld_valid       (ld_valid),
  .ld_data        (ld_data),
  .pending_q      (pending_q),
  .pend_size      (pend_size),
  .pend_zext      (pend_zext)
);

// File: tb/lsu_align_unit_bench.sv
module lsu_align_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_store, req_zext;
  logic [1:0]  req_size;
  logic [63:0] req_base, req_wsrc;
  logic [11:0] req_imm;
  logic        mem_req, mem_we, mem_rvalid, req_misaligned, ld_valid;
  logic [63:0] mem_addr, mem_wdata, mem_rdata, ld_data;
  logic [7:0]  mem_strb;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  lsu_align_unit u_lsu_align_unit (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run_op(input int st, input int sz, input int uns, input int off, input int pat);
    int n;
    logic [63:0] ea, immx, word, exp_val;
    logic [7:0]  exp_strb;
    logic [11:0] imm;
    bit          mis;
    string       tag;
    n    = 1 << sz;
    ea   = 64'h0000_4000_0000_1000 + 64'(off) + 64'(pat * 4096);
    imm  = pat[0] ? 12'(-(off * 53 + 3)) : 12'(off * 17 + 100);
    immx = {{52{imm[11]}}, imm};
    word = pat[0] ? ~64'h89AB_CDEF_0123_4567 : 64'h89AB_CDEF_0123_4567;
    mis  = (off % n) != 0;
    @(negedge clk);
    req_valid = 1; req_store = st[0]; req_size = 2'(sz); req_zext = uns[0];
    req_base  = ea - immx; req_imm = imm;
    req_wsrc  = 64'hF0E1_D2C3_B4A5_9687 ^ 64'(off * 8 + sz);
    #2;
    chk("R1 addr", mem_addr, ea);
    chk("R2 misaligned", {63'd0, req_misaligned}, {63'd0, mis});
    chk("R2 req", {63'd0, mem_req}, {63'd0, !mis});
    if (!mis) begin
      exp_strb = '0;
      exp_val  = '0;
      for (int k = 0; k < n; k++) begin
        exp_strb[off + k] = 1'b1;
        exp_val[8*(off+k) +: 8] = req_wsrc[8*k +: 8];
      end
      chk(st ? "R3 strobe" : "R5 strobe", {56'd0, mem_strb}, {56'd0, exp_strb});
      chk(st ? "R3 we" : "R5 we", {63'd0, mem_we}, {63'd0, st[0]});
      if (st != 0) chk("R4 wdata", mem_wdata, exp_val);
    end
    @(negedge clk);
    req_valid = 0; mem_rvalid = 1; mem_rdata = word;
    #2;
    if (st == 0 && !mis) begin
      exp_val = '0;
      for (int k = 0; k < n; k++) exp_val[8*k +: 8] = word[8*(off+k) +: 8];
      if (uns == 0 && n < 8 && exp_val[8*n-1])
        for (int b = 8 * n; b < 64; b++) exp_val[b] = 1'b1;
      tag = (sz == 3) ? "R9 load" : (uns != 0 ? "R8 load" : "R7 load");
      chk("R6 valid", {63'd0, ld_valid}, 64'd1);
      chk(tag, ld_data, exp_val);
    end else begin
      chk("R11 orphan", {63'd0, ld_valid}, 64'd0);
    end
    @(negedge clk);
    mem_rvalid = 0;
  endtask

  initial begin
    rst_n = 0; req_valid = 0; req_store = 0; req_size = 0; req_zext = 0;
    req_base = '0; req_imm = '0; req_wsrc = '0; mem_rvalid = 1; mem_rdata = '1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R10 reset", {63'd0, ld_valid}, 64'd0);
    rst_n = 1;
    #2;
    chk("R10 after reset", {63'd0, ld_valid}, 64'd0);
    @(negedge clk);
    mem_rvalid = 0;
    for (int st = 0; st < 2; st++)
      for (int sz = 0; sz < 4; sz++)
        for (int uns = 0; uns < 2; uns++)
          for (int off = 0; off < 8; off++)
            for (int pat = 0; pat < 2; pat++)
              run_op(st, sz, uns, off, pat);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule